// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block sits between a set of peripheral interrupt lines and a CPU. It decides which request the CPU sees next. Each source carries a two-bit level code: off, low, medium or high. A separate non-maskable line ranks above every level. Requests are latched into pending bits. The controller presents one winner at a time as a vector number together with the winner's level.

When the CPU accepts the winner it pulses `ack`. At that point the winner's pending bit clears and the in-service bit of its level is set. When a service routine ends, the CPU pulses `reti`, which retires the highest level still in service. A request is only offered while its level is strictly above every level in service. This lets a medium request interrupt a low routine, and a high request interrupt either of them.

Low-level sources can be taken in fixed order or in rotating order. Rotating order guarantees that every low source is eventually served. The vector of source `i` is a base for its peripheral group plus the position of `i` inside that group.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset no request is pending, no level is in service, `irq_valid` is low and the rotation pointer sits on the last source.
- R2: A source's pending bit is set in any cycle its request line is high, and it stays set after the line drops until that source is acknowledged.
- R3: An accepted `ack` (one given while `irq_valid` is high) clears the winner's pending bit. If the request line is still high in the cycle after the acknowledge, the source is pending again.
- R4: Among deliverable requests, high beats medium and medium beats low. Within the medium and high levels, the lowest source index wins. `irq_lvl_o` reports the winner as 0 = low, 1 = medium, 2 = high, 3 = non-maskable.
- R5: A maskable request of level L is offered only when no in-service bit of level L or above is set. An accepted `ack` sets the in-service bit of the winner's level.
- R6: `reti` clears the highest set in-service bit. If `reti` and an accepted `ack` arrive in the same cycle, the clear acts on the bits as they stood before the cycle, and the acknowledged level is set.
- R7: `lvl_en` bit 0 enables low, bit 1 medium and bit 2 high. A request of a disabled level is never offered and keeps its pending bit.
- R8: With `rr_en` low, the lowest pending low-level index wins. With `rr_en` high, the search starts at the index after the last acknowledged low source and wraps around.
- R9: A rising edge of `nmi_req` makes the non-maskable request pending. It wins over all levels regardless of `lvl_en`, and it is offered whenever its own in-service bit (bit 3) is clear. It may therefore preempt a high routine.
- R10: Source `i` has per-source level code `irq_lvl[2i+1:2i]`, where 0 = off, 1 = low, 2 = medium and 3 = high. A source coded off is never offered. Its vector is `PER_BASE + (i / SRC_PER_GRP) * GRP_STRIDE + (i % SRC_PER_GRP)`, and the non-maskable vector is `NMI_VEC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | N_SRC | Request line per source |
| irq_lvl | input | 2*N_SRC | Two-bit level code per source |
| lvl_en | input | 3 | Enable per level: low, medium, high |
| rr_en | input | 1 | Rotating order for the low level |
| nmi_req | input | 1 | Non-maskable request, captured on its rising edge |
| ack | input | 1 | CPU accepts the offered request |
| reti | input | 1 | CPU leaves the current service routine |
| irq_valid | output | 1 | A request is being offered |
| irq_vec | output | VEC_W | Vector number of the offered request |
| irq_lvl_o | output | 2 | Level of the offered request |

## Verification
The bench stresses nesting in four ways:
- It holds a medium request across its own acknowledge. A design that nests equal levels would offer it again at once.
- It stacks low, medium and high routines and retires them one at a time. A design that clears the wrong in-service bit would release the pending low source too early.
- It runs rotating order over three held low sources. A rotation that does not start after the last acknowledged index would starve one of them.
- It fires the non-maskable line while levels are disabled and while it is itself in service. A design that gates it with `lvl_en`, or nests it, would diverge from the model.

A source coded off and the last source of the last group check the vector arithmetic and the off code.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared level encodings for the priority interrupt controller.
// Assumes two-bit level codes per source and a four-entry in-service stack.
package irqc_pkg;
    // Level reported with the offered request
    typedef enum logic [1:0] {
        LV_LOW  = 2'd0,
        LV_MED  = 2'd1,
        LV_HIGH = 2'd2,
        LV_NMI  = 2'd3
    } irq_lvl_e;

    // Per-source level codes on the irq_lvl input
    localparam logic [1:0] SRC_OFF  = 2'd0;
    localparam logic [1:0] SRC_LOW  = 2'd1;
    localparam logic [1:0] SRC_MED  = 2'd2;
    localparam logic [1:0] SRC_HIGH = 2'd3;

    localparam int N_MASK_LVL = 3;
    localparam int N_SVC      = 4;
endpackage

// File: rtl/irqc_pend.sv
// Module irqc_pend
// Holds one pending bit per source. A request sets the bit, and the
// clear mask from an accepted acknowledge removes it. The clear wins over a
// request in the same cycle, so a held line is recaptured one cycle later.
module irqc_pend #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend_q
);
    // Capture requests and retire acknowledged sources
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | req) & ~clr;
    end
endmodule

// File: rtl/irqc_pick.sv
// Module irqc_pick
// Finds the lowest-indexed set bit of cand. With rotate high, indices above
// last are searched first, and the search wraps to the bottom.
// Assumes N >= 2.
module irqc_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    input  logic          rotate,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0]  upper;
    logic [IW-1:0] idx_all;
    logic [IW-1:0] idx_up;

    // Candidates strictly above the rotation point
    always_comb begin
        for (int i = 0; i < N; i++) begin
            upper[i] = rotate && cand[i] && (IW'(i) > last);
        end
    end

    // Lowest set index over all candidates and over the upper part
    always_comb begin
        idx_all = '0;
        idx_up  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i])  idx_all = IW'(i);
            if (upper[i]) idx_up  = IW'(i);
        end
    end

    // Prefer the upper part when it has a candidate
    always_comb begin
        found = |cand;
        idx   = (|upper) ? idx_up : idx_all;
    end
endmodule

// File: rtl/irqc_svc.sv
// Module irqc_svc
// In-service stack with one bit per level: bit 0 low, bit 1 medium, bit 2 high,
// bit 3 non-maskable. A return pops the highest set bit, and an acknowledge
// pushes its level. Both act on the value held before the edge.
module irqc_svc
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  irq_lvl_e         set_lvl,
    input  logic             reti,
    output logic [N_SVC-1:0] svc_q
);
    logic [N_SVC-1:0] pop;
    logic [N_SVC-1:0] push;

    // Mask of the highest set in-service bit
    always_comb begin
        pop = '0;
        for (int k = 0; k < N_SVC; k++) begin
            if (svc_q[k]) pop = N_SVC'(1) << k;
        end
    end

    // Bit to set for an accepted acknowledge
    always_comb begin
        push = set_en ? (N_SVC'(1) << set_lvl) : '0;
    end

    // Update the in-service stack
    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= (svc_q & ~(reti ? pop : '0)) | push;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module irq_prio_ctrl
// Three-level nested interrupt controller with a non-maskable input.
// Decodes per-source levels, picks one candidate per level, and offers the
// highest level that is enabled and above everything in service. It updates
// pending, in-service and rotation state on an accepted acknowledge.
// Assumes ack and reti are single-cycle pulses from the CPU side.
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int N_SRC       = 16,
    parameter int VEC_W       = 8,
    parameter int SRC_PER_GRP = 4,
    parameter int PER_BASE    = 8,
    parameter int GRP_STRIDE  = 6,
    parameter int NMI_VEC     = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   irq_req,
    input  logic [2*N_SRC-1:0] irq_lvl,
    input  logic [2:0]         lvl_en,
    input  logic               rr_en,
    input  logic               nmi_req,
    input  logic               ack,
    input  logic               reti,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [1:0]         irq_lvl_o
);
    localparam int IW = $clog2(N_SRC);

    logic [N_SRC-1:0]      pend_q;
    logic [N_SRC-1:0]      clr_mask;
    logic [N_SVC-1:0]      svc_q;
    logic                  nmi_pend;
    logic                  nmi_req_q;
    logic [IW-1:0]         rr_ptr;
    logic [N_SRC-1:0]      cand      [N_MASK_LVL];
    logic                  lvl_found [N_MASK_LVL];
    logic [IW-1:0]         lvl_idx   [N_MASK_LVL];
    logic [N_MASK_LVL-1:0] elig;
    logic [VEC_W-1:0]      vec_tab   [N_SRC];
    logic                  win_nmi;
    irq_lvl_e              win_lvl;
    logic [IW-1:0]         win_idx;
    logic                  ack_fire;

    // Per-source level decode and vector table
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        localparam int VEC_I = PER_BASE + (i / SRC_PER_GRP) * GRP_STRIDE + (i % SRC_PER_GRP);
        assign vec_tab[i] = VEC_W'(VEC_I);
        for (genvar g = 0; g < N_MASK_LVL; g++) begin : g_lv
            assign cand[g][i] = pend_q[i] && (irq_lvl[2*i +: 2] == 2'(g + 1));
        end
    end

    // One picker per maskable level; only the low level may rotate
    for (genvar g = 0; g < N_MASK_LVL; g++) begin : g_lvl
        logic rot_g;
        assign rot_g = (g == 0) ? rr_en : 1'b0;
        irqc_pick #(.N(N_SRC), .IW(IW)) u_pick (
            .cand   (cand[g]),
            .rotate (rot_g),
            .last   (rr_ptr),
            .found  (lvl_found[g]),
            .idx    (lvl_idx[g])
        );
        assign elig[g] = lvl_found[g] && lvl_en[g] && !(|svc_q[N_SVC-1:g]);
    end

    // Choose the offered request: non-maskable first, then high to low
    always_comb begin
        win_nmi   = 1'b0;
        win_lvl   = LV_LOW;
        win_idx   = '0;
        irq_valid = 1'b0;
        if (nmi_pend && !svc_q[LV_NMI]) begin
            win_nmi   = 1'b1;
            win_lvl   = LV_NMI;
            irq_valid = 1'b1;
        end else begin
            for (int g = N_MASK_LVL - 1; g >= 0; g--) begin
                if (!irq_valid && elig[g]) begin
                    irq_valid = 1'b1;
                    win_lvl   = irq_lvl_e'(g);
                    win_idx   = lvl_idx[g];
                end
            end
        end
    end

    // Drive vector and level outputs
    always_comb begin
        irq_vec   = win_nmi ? VEC_W'(NMI_VEC) : vec_tab[win_idx];
        irq_lvl_o = win_lvl;
        ack_fire  = ack && irq_valid;
        clr_mask  = (ack_fire && !win_nmi) ? (N_SRC'(1) << win_idx) : '0;
    end

    irqc_pend #(.N(N_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (irq_req),
        .clr    (clr_mask),
        .pend_q (pend_q)
    );

    irqc_svc u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ack_fire),
        .set_lvl (win_lvl),
        .reti    (reti),
        .svc_q   (svc_q)
    );

    // Non-maskable edge capture; a new edge wins over its own acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_req_q <= 1'b0;
            nmi_pend  <= 1'b0;
        end else begin
            nmi_req_q <= nmi_req;
            nmi_pend  <= (nmi_pend && !(ack_fire && win_nmi)) || (nmi_req && !nmi_req_q);
        end
    end

    // Rotation point follows the last acknowledged low source
    always_ff @(posedge clk) begin
        if (!rst_n)                                 rr_ptr <= IW'(N_SRC - 1);
        else if (ack_fire && win_lvl == LV_LOW)     rr_ptr <= win_idx;
    end
endmodule

// File: rtl/irqc_chk.sv
// Module irqc_chk
// Property checks for irq_prio_ctrl, attached by bind. Observes ports plus
// the in-service stack and the non-maskable pending bit.
module irqc_chk #(
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       lvl_en,
    input logic             ack,
    input logic             reti,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vec,
    input logic [1:0]       irq_lvl_o,
    input logic [3:0]       svc_q,
    input logic             nmi_pend
);
    // R7: an offered maskable request belongs to an enabled level
    p_lvl_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_lvl_o != 2'd3) |-> lvl_en[irq_lvl_o]);

    // R5: the offered level is above every in-service bit
    p_above_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ((svc_q >> irq_lvl_o) == 4'd0));

    // R6: a lone return removes exactly one in-service bit
    p_reti_pops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !(ack && irq_valid) && svc_q != 4'd0) |=>
        ($countones(svc_q) + 1 == $countones($past(svc_q))));

    // R9: a pending non-maskable request outside its own service is offered
    p_nmi_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !svc_q[3]) |-> (irq_valid && irq_lvl_o == 2'd3));

    // R10: the non-maskable request carries its own vector
    p_nmi_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_lvl_o == 2'd3) |-> (irq_vec == VEC_W'(NMI_VEC)));
endmodule

bind irq_prio_ctrl irqc_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_en    (lvl_en),
    .ack       (ack),
    .reti      (reti),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec),
    .irq_lvl_o (irq_lvl_o),
    .svc_q     (svc_q),
    .nmi_pend  (nmi_pend)
);

// File: tb/irq_prio_ctrl_bench.sv
// Bench for irq_prio_ctrl: a behavioural model of pending, service and
// rotation state is stepped beside the design and compared every cycle.
module irq_prio_ctrl_bench;
    localparam int N   = 16;
    localparam int VW  = 8;
    localparam int SPG = 4;
    localparam int PB  = 8;
    localparam int GS  = 6;
    localparam int NV  = 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq_req = '0;
    logic [2*N-1:0]  irq_lvl = '0;
    logic [2:0]      lvl_en = 3'b111;
    logic            rr_en = 1'b0;
    logic            nmi_req = 1'b0;
    logic            ack = 1'b0;
    logic            reti = 1'b0;
    logic            irq_valid;
    logic [VW-1:0]   irq_vec;
    logic [1:0]      irq_lvl_o;

    int  checks = 0;
    int  bad = 0;
    bit  done = 0;

    // model state
    bit  m_pend [N];
    bit  m_svc  [4];
    bit  m_nmi_p;
    bit  m_nmi_q;
    int  m_ptr;

    always #4 clk = ~clk;

    irq_prio_ctrl #(.N_SRC(N), .VEC_W(VW), .SRC_PER_GRP(SPG), .PER_BASE(PB),
                    .GRP_STRIDE(GS), .NMI_VEC(NV)) u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .lvl_en(lvl_en), .rr_en(rr_en), .nmi_req(nmi_req), .ack(ack),
        .reti(reti), .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_lvl_o(irq_lvl_o)
    );

    function automatic void model_reset();
        for (int i = 0; i < N; i++) m_pend[i] = 0;
        for (int k = 0; k < 4; k++) m_svc[k] = 0;
        m_nmi_p = 0; m_nmi_q = 0; m_ptr = N - 1;
    endfunction

    function automatic bit allowed(int l);
        for (int k = l; k < 4; k++) if (m_svc[k]) return 0;
        return 1;
    endfunction

    // expected offer from model state and current inputs
    function automatic void expect_out(output bit v, output int vec, output int lv,
                                       output int widx, output bit isnmi);
        v = 0; vec = 0; lv = 0; widx = 0; isnmi = 0;
        if (m_nmi_p && !m_svc[3]) begin
            v = 1; vec = NV; lv = 3; isnmi = 1; return;
        end
        for (int l = 2; l >= 0; l--) begin
            if (lvl_en[l] && allowed(l)) begin
                for (int k = 1; k <= N; k++) begin
                    int j;
                    j = (l == 0 && rr_en) ? (m_ptr + k) % N : k - 1;
                    if (m_pend[j] && int'(irq_lvl[2*j +: 2]) == l + 1) begin
                        v = 1; lv = l; widx = j;
                        vec = PB + (j / SPG) * GS + (j % SPG);
                        return;
                    end
                end
            end
        end
    endfunction

    // one cycle: compare at current inputs, then step model and design
    task automatic cyc(string tag);
        bit v, isnmi;
        int vec, lv, widx;
        #1;
        expect_out(v, vec, lv, widx, isnmi);
        checks++;
        if (irq_valid !== v || (v && (int'(irq_vec) != vec || int'(irq_lvl_o) != lv))) begin
            bad++;
            $display("FAIL %s: valid=%0b vec=%0d lvl=%0d, expected valid=%0b vec=%0d lvl=%0d",
                     tag, irq_valid, irq_vec, irq_lvl_o, v, vec, lv);
        end
        @(posedge clk);
        begin
            bit fire;
            fire = ack && v;
            for (int i = 0; i < N; i++) m_pend[i] = m_pend[i] | irq_req[i];
            if (fire && !isnmi) m_pend[widx] = 0;
            if (reti) begin
                for (int k = 3; k >= 0; k--) if (m_svc[k]) begin m_svc[k] = 0; break; end
            end
            if (fire) m_svc[lv] = 1;
            if (fire && isnmi) m_nmi_p = 0;
            if (nmi_req && !m_nmi_q) m_nmi_p = 1;
            m_nmi_q = nmi_req;
            if (fire && lv == 0) m_ptr = widx;
        end
        @(negedge clk);
        ack = 0; reti = 0;
    endtask

    task automatic set_code(int i, logic [1:0] c);
        irq_lvl[2*i +: 2] = c;
    endtask

    task automatic pulse(logic [N-1:0] m, string tag);
        irq_req = m; cyc(tag); irq_req = '0;
    endtask

    task automatic take_ret(string tag);
        ack = 1; cyc(tag); reti = 1; cyc(tag);
    endtask

    initial begin
        set_code(5, 2'd1); set_code(3, 2'd1); set_code(1, 2'd1);
        set_code(4, 2'd1); set_code(7, 2'd1);
        set_code(2, 2'd2); set_code(9, 2'd2); set_code(6, 2'd2);
        set_code(12, 2'd3); set_code(15, 2'd3); set_code(14, 2'd0);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) cyc("R1");

        // R2: short pulse stays pending
        pulse(N'(1) << 5, "R2");
        repeat (3) cyc("R2");
        // R3: acknowledge clears it
        ack = 1; cyc("R3"); cyc("R3");
        reti = 1; cyc("R6");
        // R3/R5: held medium line recaptured, not nested at same level
        irq_req = N'(1) << 2;
        cyc("R3"); ack = 1; cyc("R3"); cyc("R5"); cyc("R5");
        reti = 1; cyc("R6"); cyc("R3");
        irq_req = '0; take_ret("R3"); cyc("R3");

        // R4: mixed levels at once
        pulse((N'(1) << 3) | (N'(1) << 9) | (N'(1) << 6) | (N'(1) << 12), "R4");
        for (int k = 0; k < 4; k++) begin
            cyc("R4"); ack = 1; cyc("R4"); cyc("R5"); reti = 1; cyc("R6");
        end
        cyc("R4");

        // R5: nesting low -> medium -> high, low waits
        pulse(N'(1) << 3, "R5"); ack = 1; cyc("R5");
        pulse(N'(1) << 9, "R5"); ack = 1; cyc("R5");
        pulse(N'(1) << 12, "R5"); ack = 1; cyc("R5");
        pulse(N'(1) << 1, "R5"); cyc("R5");
        // R6: return and acknowledge together
        reti = 1; cyc("R6"); cyc("R6");
        reti = 1; cyc("R6"); cyc("R6");
        pulse(N'(1) << 9, "R6"); ack = 1; reti = 1; cyc("R6"); cyc("R6");
        reti = 1; cyc("R6"); cyc("R6");
        reti = 1; cyc("R6");
        take_ret("R5"); cyc("R5");

        // R7: level enables
        lvl_en = 3'b101; pulse(N'(1) << 9, "R7"); repeat (2) cyc("R7");
        lvl_en = 3'b111; cyc("R7"); take_ret("R7");
        lvl_en = 3'b000; pulse(N'(1) << 3, "R7"); cyc("R7");
        lvl_en = 3'b111; cyc("R7"); take_ret("R7");

        // R8: rotating then fixed order among held low sources
        rr_en = 1;
        irq_req = (N'(1) << 1) | (N'(1) << 4) | (N'(1) << 7);
        for (int k = 0; k < 6; k++) take_ret("R8");
        rr_en = 0;
        for (int k = 0; k < 3; k++) take_ret("R8");
        irq_req = '0;
        for (int k = 0; k < 4; k++) take_ret("R8");
        cyc("R8");

        // R9: non-maskable above everything, not nested with itself
        lvl_en = 3'b000;
        nmi_req = 1; cyc("R9"); nmi_req = 0; cyc("R9");
        ack = 1; cyc("R9"); cyc("R9");
        nmi_req = 1; cyc("R9"); nmi_req = 0; cyc("R9");
        lvl_en = 3'b111;
        pulse(N'(1) << 12, "R9"); cyc("R9");
        reti = 1; cyc("R9"); cyc("R9");
        ack = 1; cyc("R9"); reti = 1; cyc("R9");
        cyc("R9"); take_ret("R9");
        pulse(N'(1) << 12, "R9"); ack = 1; cyc("R9");
        nmi_req = 1; cyc("R9"); nmi_req = 0; take_ret("R9"); reti = 1; cyc("R9");

        // R10: off code never offered; last source vector
        pulse(N'(1) << 14, "R10"); repeat (3) cyc("R10");
        pulse(N'(1) << 15, "R10"); cyc("R10"); take_ret("R10"); cyc("R10");

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule